// File: doc/BRIEF.md
# Programmable Sync Output Conditioner

This block prepares the horizontal (or composite) sync and the vertical sync of a display pipeline for the output pads. Horizontal sync passes through a tapped shift register. The tap can be set to add between 0 and 15 clock cycles to a fixed two-cycle base latency, so that the sync edge arrives together with the pixel data that went through the colour pipeline. A mismatch would shift the picture sideways on the screen. Vertical sync needs no such matching. It is retimed by one register and then goes through the same output stage.

Each sync has its own four control bits. The output stage applies them in a fixed priority: tri-state first, then a forced level, then inversion of the incoming sync. The stage produces a drive value and an output-enable for the pad. A power-down input tri-states both syncs and empties the horizontal delay line, so no stale sync edge is sent once the outputs come back.

The control bits are held in configuration registers inside the block. A change on the configuration inputs reaches the outputs two clock edges later.

Top module: `sync_out_cond`

## Requirements
- R1: With no control bit set, `hsDrive` equals the `hsyncIn` value sampled `hsPos + 2` rising edges earlier, for every `hsPos` from 0 to 15.
- R2: Invert bit `syncCtrl[0]` makes `hsDrive` the complement of the delayed horizontal sync, with `hsOe` high.
- R3: Force-enable bit `syncCtrl[1]` makes `hsDrive` equal to the force-level bit `syncCtrl[2]`, whatever the input and the invert bit are, with `hsOe` high.
- R4: Tri-state bit `syncCtrl[3]` drives `hsOe` and `hsDrive` low, and takes priority over the force and invert bits.
- R5: Vertical sync uses `syncCtrl[7:4]` with the same bit meanings as R2 to R4 (invert at bit 4, force-enable at 5, force level at 6, tri-state at 7) and has a fixed latency of 2 rising edges from `vsyncIn` to `vsDrive`.
- R6: While `pwrDown` is high, both outputs are tri-stated (enable low, drive low) and the horizontal delay line is cleared. After `pwrDown` falls, `hsDrive` stays low until a sync value that was sampled after the release reaches the tap.
- R7: During reset, all four outputs are low.
- R8: A change on `syncCtrl`, `hsPos` or `pwrDown` appears at the outputs after exactly two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| hsyncIn | input | 1 | Incoming horizontal or composite sync |
| vsyncIn | input | 1 | Incoming vertical sync |
| syncCtrl | input | 8 | Per-sync control bits: horizontal in [3:0], vertical in [7:4] |
| hsPos | input | 4 | Extra horizontal sync delay, in clock cycles |
| pwrDown | input | 1 | Tri-states both syncs and clears the delay line |
| hsDrive | output | 1 | Horizontal sync pad drive value |
| hsOe | output | 1 | Horizontal sync pad output-enable |
| vsDrive | output | 1 | Vertical sync pad drive value |
| vsOe | output | 1 | Vertical sync pad output-enable |

## Verification
The bench sends a single rising sync edge through the delay line at tap positions 0, 3 and 15. A fault in the shift chain or in the tap selection therefore shows up as an edge that arrives one or more cycles too early or too late, and the edge is checked one cycle before and in the cycle it is due. A delay line that does not clear on power-down can only be seen once the outputs are enabled again. It shows as a high drive level in the second cycle after release, before any newly sampled sync can reach the tap. An error in the priority decoding shows at once, on the first output update after the control bits change, because tri-state, force and invert are set together in the tests.

// File: rtl/syncout_pkg.sv
package syncout_pkg;

  // Resolved per-channel output controls, priority already applied.
  typedef struct packed {
    logic oe;       // output-enable towards the pad
    logic forceOn;  // drive the force level instead of the sync
    logic level;    // forced level
    logic inv;      // invert the delayed sync
  } chanCtl_t;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    chanCtl_t hs;
    chanCtl_t vs;
    logic     clear; // empty the horizontal delay line
  } syncStrobes_t;

endpackage

// File: rtl/syncout_ctrl.sv
module syncout_ctrl
  import syncout_pkg::*;
#(
  parameter int POS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       syncCtrl,
  input  logic [POS_W-1:0] hsPos,
  input  logic             pwrDown,
  output syncStrobes_t     strobes,
  output logic [POS_W-1:0] tapSel
);

  // Bit positions inside one 4-bit channel nibble.
  localparam int B_INV = 0;
  localparam int B_FEN = 1;
  localparam int B_LVL = 2;
  localparam int B_TRI = 3;

  logic [7:0]       ctrlQ;
  logic [POS_W-1:0] posQ;
  logic             pwrQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlQ <= '0;
      posQ  <= '0;
      pwrQ  <= 1'b0;
    end else begin
      ctrlQ <= syncCtrl;
      posQ  <= hsPos;
      pwrQ  <= pwrDown;
    end
  end

  // Priority: tri-state, then forced level, then inversion.
  function automatic chanCtl_t resolve(input logic [3:0] nib, input logic off);
    chanCtl_t c;
    c.oe      = !(nib[B_TRI] || off);
    c.forceOn = c.oe && nib[B_FEN];
    c.level   = nib[B_LVL];
    c.inv     = c.oe && !nib[B_FEN] && nib[B_INV];
    return c;
  endfunction

  always_comb begin
    strobes.hs    = resolve(ctrlQ[3:0], pwrQ);
    strobes.vs    = resolve(ctrlQ[7:4], pwrQ);
    strobes.clear = pwrQ;
  end

  assign tapSel = posQ;

endmodule

// File: rtl/syncout_path.sv
module syncout_path
  import syncout_pkg::*;
#(
  parameter int POS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsyncIn,
  input  logic             vsyncIn,
  input  syncStrobes_t     strobes,
  input  logic [POS_W-1:0] tapSel,
  output logic             hsDrive,
  output logic             hsOe,
  output logic             vsDrive,
  output logic             vsOe
);

  localparam int DEPTH = 1 << POS_W;

  logic [DEPTH-1:0] dlLine;
  logic             vsQ;
  logic             hsTap;

  // Horizontal delay line; stage 0 is the input register.
  always_ff @(posedge clk) begin
    if (rst || strobes.clear) dlLine <= '0;
    else                      dlLine <= {dlLine[DEPTH-2:0], hsyncIn};
  end

  assign hsTap = dlLine[tapSel];

  // Vertical sync retiming stage.
  always_ff @(posedge clk) begin
    if (rst) vsQ <= 1'b0;
    else     vsQ <= vsyncIn;
  end

  function automatic logic [1:0] shape(input chanCtl_t c, input logic d);
    logic drv;
    if (!c.oe)         drv = 1'b0;
    else if (c.forceOn) drv = c.level;
    else               drv = d ^ c.inv;
    return {drv, c.oe};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      {hsDrive, hsOe} <= 2'b00;
      {vsDrive, vsOe} <= 2'b00;
    end else begin
      {hsDrive, hsOe} <= shape(strobes.hs, hsTap);
      {vsDrive, vsOe} <= shape(strobes.vs, vsQ);
    end
  end

  p_shift_in_r1: assert property (@(posedge clk) disable iff (rst)
    !strobes.clear |=> dlLine[0] == $past(hsyncIn));

  p_invert_r2: assert property (@(posedge clk) disable iff (rst)
    (strobes.hs.inv && !strobes.hs.forceOn) |=> (hsOe && hsDrive == !$past(hsTap)));

  p_force_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.hs.forceOn |=> (hsOe && hsDrive == $past(strobes.hs.level)));

  p_hiz_r4: assert property (@(posedge clk) disable iff (rst)
    !strobes.hs.oe |=> (!hsOe && !hsDrive));

  p_vs_force_r5: assert property (@(posedge clk) disable iff (rst)
    strobes.vs.forceOn |=> (vsOe && vsDrive == $past(strobes.vs.level)));

  p_pwr_clear_r6: assert property (@(posedge clk) disable iff (rst)
    strobes.clear |=> (dlLine == '0 && !hsOe && !vsOe));

endmodule

// File: rtl/sync_out_cond.sv
module sync_out_cond
  import syncout_pkg::*;
#(
  parameter int POS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsyncIn,
  input  logic             vsyncIn,
  input  logic [7:0]       syncCtrl,
  input  logic [POS_W-1:0] hsPos,
  input  logic             pwrDown,
  output logic             hsDrive,
  output logic             hsOe,
  output logic             vsDrive,
  output logic             vsOe
);

  syncStrobes_t     strobes;
  logic [POS_W-1:0] tapSel;

  syncout_ctrl #(.POS_W(POS_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .syncCtrl (syncCtrl),
    .hsPos    (hsPos),
    .pwrDown  (pwrDown),
    .strobes  (strobes),
    .tapSel   (tapSel)
  );

  syncout_path #(.POS_W(POS_W)) u_path (
    .clk     (clk),
    .rst     (rst),
    .hsyncIn (hsyncIn),
    .vsyncIn (vsyncIn),
    .strobes (strobes),
    .tapSel  (tapSel),
    .hsDrive (hsDrive),
    .hsOe    (hsOe),
    .vsDrive (vsDrive),
    .vsOe    (vsOe)
  );

  p_reset_quiet_r7: assert property (@(posedge clk)
    rst |=> (!hsOe && !hsDrive && !vsOe && !vsDrive));

endmodule

// File: tb/sync_out_cond_test.sv
module sync_out_cond_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       hsyncIn, vsyncIn, pwrDown;
  logic [7:0] syncCtrl;
  logic [3:0] hsPos;
  logic       hsDrive, hsOe, vsDrive, vsOe;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  sync_out_cond uut (
    .clk(clk), .rst(rst), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .syncCtrl(syncCtrl), .hsPos(hsPos), .pwrDown(pwrDown),
    .hsDrive(hsDrive), .hsOe(hsOe), .vsDrive(vsDrive), .vsOe(vsOe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; hsyncIn = 1'b1; vsyncIn = 1'b1; syncCtrl = 8'h00; hsPos = 4'd0; pwrDown = 1'b0;
    tick(3);
    check("R7", "hs {drive,oe} in reset", {hsDrive, hsOe}, 2'b00);
    check("R7", "vs {drive,oe} in reset", {vsDrive, vsOe}, 2'b00);
    rst = 1'b0;
    hsyncIn = 1'b0; vsyncIn = 1'b0;
    tick(20);
  endtask

  // Rising edge must appear exactly pos+2 edges after it is sampled.
  task automatic t_hs_latency(input logic [3:0] pos);
    hsPos = pos; syncCtrl = 8'h00; hsyncIn = 1'b0;
    tick(20);
    hsyncIn = 1'b1;
    tick(int'(pos) + 1);
    check("R1", $sformatf("hs before edge pos=%0d", pos), {hsDrive, hsOe}, 2'b01);
    tick(1);
    check("R1", $sformatf("hs edge pos=%0d", pos), {hsDrive, hsOe}, 2'b11);
    hsyncIn = 1'b0;
    tick(20);
  endtask

  task automatic t_invert;
    hsPos = 4'd2; hsyncIn = 1'b0; syncCtrl = 8'h01;
    tick(20);
    check("R2", "inverted low input", {hsDrive, hsOe}, 2'b11);
    hsyncIn = 1'b1;
    tick(4);
    check("R2", "inverted high input", {hsDrive, hsOe}, 2'b01);
    hsyncIn = 1'b0;
    tick(20);
  endtask

  task automatic t_force;
    hsPos = 4'd0; hsyncIn = 1'b0; syncCtrl = 8'h07; // force high, invert also set
    tick(20);
    check("R3", "force high over low input", {hsDrive, hsOe}, 2'b11);
    hsyncIn = 1'b1; syncCtrl = 8'h03;                // force low, invert also set
    tick(20);
    check("R3", "force low over high input", {hsDrive, hsOe}, 2'b01);
    hsyncIn = 1'b0;
  endtask

  task automatic t_tristate;
    syncCtrl = 8'h0F; hsyncIn = 1'b1;
    tick(20);
    check("R4", "tri-state over force/invert", {hsDrive, hsOe}, 2'b00);
    check("R4", "vs unaffected by hs tri-state", {vsDrive, vsOe}, 2'b01);
    syncCtrl = 8'h00; hsyncIn = 1'b0;
    tick(20);
  endtask

  task automatic t_vsync;
    syncCtrl = 8'h10; vsyncIn = 1'b0;
    tick(20);
    vsyncIn = 1'b1;
    tick(1);
    check("R5", "vs inverted before edge", {vsDrive, vsOe}, 2'b11);
    tick(1);
    check("R5", "vs inverted edge at 2", {vsDrive, vsOe}, 2'b01);
    syncCtrl = 8'h60; // force high
    vsyncIn = 1'b0;
    tick(20);
    check("R5", "vs forced high", {vsDrive, vsOe}, 2'b11);
    syncCtrl = 8'hE0; // tri-state over force
    tick(20);
    check("R5", "vs tri-state", {vsDrive, vsOe}, 2'b00);
    syncCtrl = 8'h00;
    tick(20);
  endtask

  task automatic t_config_latency;
    syncCtrl = 8'h00; hsyncIn = 1'b0; hsPos = 4'd0;
    tick(20);
    syncCtrl = 8'h06; // force high
    tick(1);
    check("R8", "cfg not yet visible after 1 edge", {hsDrive, hsOe}, 2'b01);
    tick(1);
    check("R8", "cfg visible after 2 edges", {hsDrive, hsOe}, 2'b11);
    syncCtrl = 8'h00;
    tick(20);
  endtask

  task automatic t_power;
    hsPos = 4'd5; syncCtrl = 8'h00; hsyncIn = 1'b1; vsyncIn = 1'b1;
    tick(25);
    check("R6", "hs high before power-down", {hsDrive, hsOe}, 2'b11);
    pwrDown = 1'b1;
    tick(3);
    check("R6", "hs hi-z while powered down", {hsDrive, hsOe}, 2'b00);
    check("R6", "vs hi-z while powered down", {vsDrive, vsOe}, 2'b00);
    pwrDown = 1'b0;
    tick(2);
    check("R6", "line cleared after release", {hsDrive, hsOe}, 2'b01);
    tick(5);
    check("R6", "still cleared at 7 edges", {hsDrive, hsOe}, 2'b01);
    tick(1);
    check("R6", "new sync reaches output at 8", {hsDrive, hsOe}, 2'b11);
    hsyncIn = 1'b0; vsyncIn = 1'b0;
    tick(20);
  endtask

  initial begin
    t_reset();
    t_hs_latency(4'd0);
    t_hs_latency(4'd3);
    t_hs_latency(4'd15);
    t_invert();
    t_force();
    t_tristate();
    t_vsync();
    t_config_latency();
    t_power();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #200000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule